// File: doc/BRIEF.md
# Selectable Clock Output Divider

This block produces three clock outputs from two source clocks. Output A comes from the secondary source clock. Outputs B and C come from the primary source clock, which nominally runs at 33.8688 MHz. Each output has its own 4-bit configuration field, made of an enable bit and a 3-bit ratio code. Through the code, the output either follows its source, divides it, or stops and is held low.

The configuration fields are written through a small synchronous write port in the primary clock domain. The field for output A crosses into the secondary domain through a synchronizer. A new value is accepted there only after it has been seen unchanged for two consecutive secondary cycles.

Every ratio change waits for the end of the current output period. The new ratio then starts with a low phase. As a result, no output ever shows a high or low pulse shorter than half a cycle of its source clock. Apart from the pass-through ratio, every output is a registered signal. The pass-through ratio is gated by an enable that is updated on the falling edge of the source clock.

Top module: `clk_ratio_out`

## Requirements
- R1: Output A, with enable=1, follows the secondary clock for code 0 and divides it by 2 (50% duty) for code 1.
- R2: Output B, with enable=1, gives the primary clock divided by 1, 2, 512 for codes 0, 1, 3. The /2 and /512 ratios have a 50% duty cycle.
- R3: Output C, with enable=1, gives the primary clock divided by 1, 5, 512 for codes 0, 2, 3. For code 1 it gives two one-cycle pulses per five primary cycles, never on adjacent cycles.
- R4: The /5 ratio on outputs B and C is low for 3 source cycles and then high for 2.
- R5: An output is held low when its enable bit is 0, when its code is 7, or when its code is not listed for that output. Codes 4 to 6 are unlisted for all outputs, and codes 2 and 3 are unlisted for output A.
- R6: A ratio change takes effect only at the end of the current output period, and the new ratio begins low. No high or low pulse is shorter than half a source cycle. A running /512 high phase lasts its full 256 cycles, even when a new code is written during that phase.
- R7: A write with wr_addr 0, 1 or 2 loads wr_data into the field of output A, B or C. In that field, wr_data[3] is the enable bit and wr_data[2:0] is the code. A write with wr_addr 3 changes nothing.
- R8: While rst_n is low, all outputs are low. After reset, every field reads enable=1 with code 0, so every output follows its source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pri | input | 1 | Primary source clock; also clocks the write port |
| clk_sec | input | 1 | Secondary source clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_en | input | 1 | Write strobe for a configuration field |
| wr_addr | input | 2 | Field select: 0 = A, 1 = B, 2 = C, 3 = unmapped |
| wr_data | input | 4 | Bit 3 = enable, bits 2:0 = ratio code |
| clk_out_a | output | 1 | Output derived from clk_sec |
| clk_out_b | output | 1 | Output derived from clk_pri (/1, /2, /5, /512) |
| clk_out_c | output | 1 | Output derived from clk_pri (/1, 2/5, /5, /512) |

## Verification
The assertions check the following on every cycle:
- a channel's mode changes only at a period boundary, and the counter and output are low when it does;
- the /2 output toggles on each source cycle;
- a stopped channel keeps its register and gate low;
- a write to the unmapped address leaves all fields stable.

Other behaviours can only be shown by the bench's scenarios, which sample each output in both halves of every source cycle:
- the pulse counts and high time for each ratio;
- the non-adjacent pulse spacing of the 2/5 pattern;
- the complete /512 high phase when a new code is written during it;
- the absence of short pulses across all ratio switches.

// File: rtl/clkout_pkg.sv
`timescale 1ns/1ps
package clkout_pkg;
  localparam int CFG_W = 4;
  localparam logic [CFG_W-1:0] CFG_RST = 4'b1000;
  typedef enum logic [2:0] {
    M_STOP, M_DIV1, M_DIV2, M_DIV5, M_FRAC, M_SLOW
  } mode_e;
endpackage

// File: rtl/clkout_rst_sync.sv
`timescale 1ns/1ps
module clkout_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/clkout_regs.sv
`timescale 1ns/1ps
module clkout_regs
  import clkout_pkg::*;
#(
  parameter int N_OUT = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [1:0]                   wr_addr_i,
  input  logic [CFG_W-1:0]             wr_data_i,
  output logic [N_OUT-1:0][CFG_W-1:0]  cfg_o
);
  logic [N_OUT-1:0][CFG_W-1:0] cfg_q, cfg_d;
  logic [N_OUT-1:0]            hit;

  for (genvar i = 0; i < N_OUT; i++) begin : g_field
    assign hit[i] = wr_en_i && (wr_addr_i == 2'(i));
    always_comb begin
      cfg_d[i] = cfg_q[i];
      if (hit[i]) cfg_d[i] = wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= {N_OUT{CFG_RST}};
    else         cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

  AST_UNMAPPED_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd3) |=> $stable(cfg_q)); // R7
endmodule

// File: rtl/clkout_cfg_sync.sv
`timescale 1ns/1ps
module clkout_cfg_sync
  import clkout_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  output logic [CFG_W-1:0] cfg_o
);
  logic [CFG_W-1:0] s1_q, s2_q, s3_q, hold_q, hold_d;
  logic             settled;

  assign settled = (s2_q == s3_q);

  always_comb begin
    hold_d = hold_q;
    if (settled) hold_d = s3_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= CFG_RST;
      s2_q   <= CFG_RST;
      s3_q   <= CFG_RST;
      hold_q <= CFG_RST;
    end else begin
      s1_q   <= cfg_i;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      hold_q <= hold_d;
    end
  end

  assign cfg_o = hold_q;
endmodule

// File: rtl/clkout_chan.sv
`timescale 1ns/1ps
module clkout_chan
  import clkout_pkg::*;
#(
  parameter bit FRAC_ON_1 = 1'b0,
  parameter bit WIDE_SET  = 1'b1,
  parameter int SLOW_DIV  = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             clk_o
);
  localparam int              CNT_W     = $clog2(SLOW_DIV);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_DIV - 1);
  localparam logic [CNT_W-1:0] SLOW_HALF = CNT_W'(SLOW_DIV / 2);

  mode_e            req_mode, cur_q, cur_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, last_cnt;
  logic             q_q, q_d, hi_next, at_wrap, g1_q;

  always_comb begin
    req_mode = M_STOP;
    if (cfg_i[3]) begin
      case (cfg_i[2:0])
        3'd0: req_mode = M_DIV1;
        3'd1: req_mode = FRAC_ON_1 ? M_FRAC : M_DIV2;
        3'd2: req_mode = WIDE_SET ? M_DIV5 : M_STOP;
        3'd3: req_mode = WIDE_SET ? M_SLOW : M_STOP;
        default: req_mode = M_STOP;
      endcase
    end
  end

  always_comb begin
    case (cur_q)
      M_DIV2:         last_cnt = CNT_W'(1);
      M_DIV5, M_FRAC: last_cnt = CNT_W'(4);
      M_SLOW:         last_cnt = SLOW_LAST;
      default:        last_cnt = '0;
    endcase
  end

  assign at_wrap = (cnt_q == last_cnt);
  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    case (cur_q)
      M_DIV2:  hi_next = (cnt_inc == CNT_W'(1));
      M_DIV5:  hi_next = (cnt_inc >= CNT_W'(3));
      M_FRAC:  hi_next = (cnt_inc == CNT_W'(1)) || (cnt_inc == CNT_W'(3));
      M_SLOW:  hi_next = (cnt_inc >= SLOW_HALF);
      default: hi_next = 1'b0;
    endcase
  end

  always_comb begin
    if (at_wrap) begin
      cur_d = req_mode;
      cnt_d = '0;
      q_d   = 1'b0;
    end else begin
      cur_d = cur_q;
      cnt_d = cnt_inc;
      q_d   = hi_next;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= M_STOP;
      cnt_q <= '0;
      q_q   <= 1'b0;
    end else begin
      cur_q <= cur_d;
      cnt_q <= cnt_d;
      q_q   <= q_d;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) g1_q <= 1'b0;
    else         g1_q <= (cur_q == M_DIV1);
  end

  assign clk_o = (clk_i & g1_q) | q_q;

  AST_SWITCH_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q != $past(cur_q)) |-> $past(at_wrap)); // R6
  AST_NEW_MODE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q != $past(cur_q)) |-> (!q_q && cnt_q == '0)); // R6
  AST_HALF_TOGGLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q == M_DIV2 && $past(cur_q) == M_DIV2) |-> (q_q != $past(q_q))); // R2
  AST_STOP_HELD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q == M_STOP && $past(cur_q) == M_STOP) |-> (!q_q && !g1_q)); // R5
endmodule

// File: rtl/clk_ratio_out.sv
`timescale 1ns/1ps
module clk_ratio_out
  import clkout_pkg::*;
(
  input  logic       clk_pri,
  input  logic       clk_sec,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [3:0] wr_data,
  output logic       clk_out_a,
  output logic       clk_out_b,
  output logic       clk_out_c
);
  logic                  rst_pri_n, rst_sec_n;
  logic [2:0][CFG_W-1:0] cfg;
  logic [CFG_W-1:0]      cfg_a_sec;

  clkout_rst_sync u_rst_pri (.clk_i(clk_pri), .arst_ni(rst_n), .rst_no(rst_pri_n));
  clkout_rst_sync u_rst_sec (.clk_i(clk_sec), .arst_ni(rst_n), .rst_no(rst_sec_n));

  clkout_regs #(.N_OUT(3)) u_regs (
    .clk_i(clk_pri), .rst_ni(rst_pri_n), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .cfg_o(cfg)
  );

  clkout_cfg_sync u_sync_a (
    .clk_i(clk_sec), .rst_ni(rst_sec_n), .cfg_i(cfg[0]), .cfg_o(cfg_a_sec)
  );

  clkout_chan #(.FRAC_ON_1(1'b0), .WIDE_SET(1'b0), .SLOW_DIV(512)) u_chan_a (
    .clk_i(clk_sec), .rst_ni(rst_sec_n), .cfg_i(cfg_a_sec), .clk_o(clk_out_a)
  );
  clkout_chan #(.FRAC_ON_1(1'b0), .WIDE_SET(1'b1), .SLOW_DIV(512)) u_chan_b (
    .clk_i(clk_pri), .rst_ni(rst_pri_n), .cfg_i(cfg[1]), .clk_o(clk_out_b)
  );
  clkout_chan #(.FRAC_ON_1(1'b1), .WIDE_SET(1'b1), .SLOW_DIV(512)) u_chan_c (
    .clk_i(clk_pri), .rst_ni(rst_pri_n), .cfg_i(cfg[2]), .clk_o(clk_out_c)
  );
endmodule

// File: tb/clk_ratio_out_tb.sv
`timescale 1ns/1ps
module clk_ratio_out_tb;
  logic clk_pri = 1'b0, clk_sec = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic clk_out_a, clk_out_b, clk_out_c;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk_pri = ~clk_pri;
  always #3.5 clk_sec = ~clk_sec;

  clk_ratio_out u_dut (.*);

  typedef struct packed {
    logic [1:0]  addr;
    logic [3:0]  data;
    logic [11:0] win;
    logic [11:0] rises;
    logic [11:0] highs;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [15] = '{
    '{2'd1, 4'h9, 12'd20,   12'd10, 12'd20,   4'd2}, // R2 /2
    '{2'd1, 4'hA, 12'd20,   12'd4,  12'd16,   4'd4}, // R4 /5 low3 high2
    '{2'd1, 4'hB, 12'd1024, 12'd2,  12'd1024, 4'd2}, // R2 /512
    '{2'd1, 4'hD, 12'd20,   12'd0,  12'd0,    4'd5}, // R5 reserved code 5
    '{2'd1, 4'hF, 12'd20,   12'd0,  12'd0,    4'd5}, // R5 code 7
    '{2'd1, 4'h8, 12'd20,   12'd20, 12'd20,   4'd2}, // R2 /1
    '{2'd2, 4'h9, 12'd20,   12'd8,  12'd16,   4'd3}, // R3 2/5
    '{2'd2, 4'hA, 12'd20,   12'd4,  12'd16,   4'd4}, // R4 /5 on C
    '{2'd2, 4'hB, 12'd1024, 12'd2,  12'd1024, 4'd3}, // R3 /512
    '{2'd2, 4'h0, 12'd20,   12'd0,  12'd0,    4'd5}, // R5 enable off
    '{2'd2, 4'h8, 12'd20,   12'd20, 12'd20,   4'd3}, // R3 /1
    '{2'd0, 4'h9, 12'd20,   12'd10, 12'd20,   4'd1}, // R1 /2
    '{2'd0, 4'hA, 12'd20,   12'd0,  12'd0,    4'd5}, // R5 code 2 unlisted on A
    '{2'd0, 4'h1, 12'd20,   12'd0,  12'd0,    4'd5}, // R5 enable off on A
    '{2'd0, 4'h8, 12'd20,   12'd20, 12'd20,   4'd1}  // R1 /1
  };

  function automatic logic pick(input int ch);
    return (ch == 0) ? clk_out_a : (ch == 1) ? clk_out_b : clk_out_c;
  endfunction

  task automatic check(input int req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk_pri);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk_pri);
    wr_en = 1'b0;
  endtask

  task automatic half(input int ch, input bit rise);
    if (ch == 0) begin
      if (rise) @(posedge clk_sec); else @(negedge clk_sec);
    end else begin
      if (rise) @(posedge clk_pri); else @(negedge clk_pri);
    end
    #1;
  endtask

  task automatic measure(input int ch, input int ncyc, output int rises, output int highs);
    logic prev, s;
    rises = 0; highs = 0;
    half(ch, 1'b0);
    prev = pick(ch);
    for (int i = 0; i < 2 * ncyc; i++) begin
      half(ch, (i % 2) == 0);
      s = pick(ch);
      if (s && !prev) rises++;
      if (s) highs++;
      prev = s;
    end
  endtask

  // Pulse width monitor for R6
  int  glitches = 0;
  realtime tr[3], tf[3];
  initial for (int i = 0; i < 3; i++) begin tr[i] = -1.0; tf[i] = -1.0; end
  task automatic edge_seen(input int ch, input bit rising);
    realtime thr;
    thr = (ch == 0) ? 3.4 : 2.4;
    if (rising) begin
      if (tf[ch] >= 0.0 && ($realtime - tf[ch]) < thr) glitches++;
      tr[ch] = $realtime;
    end else begin
      if (tr[ch] >= 0.0 && ($realtime - tr[ch]) < thr) glitches++;
      tf[ch] = $realtime;
    end
  endtask
  always @(posedge clk_out_a) edge_seen(0, 1'b1);
  always @(negedge clk_out_a) edge_seen(0, 1'b0);
  always @(posedge clk_out_b) edge_seen(1, 1'b1);
  always @(negedge clk_out_b) edge_seen(1, 1'b0);
  always @(posedge clk_out_c) edge_seen(2, 1'b1);
  always @(negedge clk_out_c) edge_seen(2, 1'b0);

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int r, h, any_high, cnt;
    // R8: outputs low while reset is held
    any_high = 0;
    for (int i = 0; i < 20; i++) begin
      half(1, (i % 2) == 0);
      any_high += int'(clk_out_a | clk_out_b | clk_out_c);
    end
    check(8, "high samples during reset", any_high, 0);
    rst_n = 1'b1;
    repeat (20) @(posedge clk_pri);
    for (int ch = 0; ch < 3; ch++) begin
      measure(ch, 20, r, h);
      check(8, $sformatf("post-reset /1 rises ch%0d", ch), r, 20);
    end

    foreach (VECS[i]) begin
      wr(VECS[i].addr, VECS[i].data);
      repeat (1100) @(posedge clk_pri);
      measure(int'(VECS[i].addr), int'(VECS[i].win), r, h);
      check(int'(VECS[i].req), $sformatf("vec%0d rises", i), r, int'(VECS[i].rises));
      check(int'(VECS[i].req), $sformatf("vec%0d highs", i), h, int'(VECS[i].highs));
    end

    // R7: unmapped address leaves every field unchanged
    wr(2'd1, 4'h9);
    repeat (20) @(posedge clk_pri);
    wr(2'd3, 4'h0);
    repeat (40) @(posedge clk_pri);
    measure(1, 20, r, h);
    check(7, "B still /2 after addr 3 write", r, 10);
    measure(2, 20, r, h);
    check(7, "C still /1 after addr 3 write", r, 20);
    measure(0, 20, r, h);
    check(7, "A still /1 after addr 3 write", r, 20);

    // R6: code written in a /512 high phase; the phase completes, then /1 starts after one low cycle
    wr(2'd1, 4'hB);
    repeat (1100) @(posedge clk_pri);
    do half(1, 1'b1); while (!clk_out_b);
    cnt = 1;
    fork
      wr(2'd1, 4'h8);
      begin
        for (int i = 1; ; i++) begin
          half(1, (i % 2) == 0);
          if (!clk_out_b) break;
          cnt++;
        end
      end
    join
    check(6, "full /512 high phase (half samples)", cnt, 512);
    cnt = 1;
    for (int i = 0; ; i++) begin
      half(1, (i % 2) == 1);
      if (clk_out_b) break;
      cnt++;
    end
    check(6, "low gap before /1 (half samples)", cnt, 2);
    check(6, "short pulses seen", glitches, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule